// File: doc/BRIEF.md
# Edge-Triggered Event Counter with Compare

This block counts transitions of an asynchronous event pin. The counter only advances while an enable bit is set. The pin is brought into the clock domain through a synchronizer chain. A two-bit selector then decides which transitions are valid: none, rising, falling or both. Each valid transition advances a counter whose width is set by a parameter (16 bits by default). When the counter reaches the active compare value, a one-clock interrupt pulse is raised. On the next valid transition the counter returns to zero, so a compare value D gives an interrupt every D+1 valid transitions.

Software writes the compare input at any time. The match logic does not use that input directly. It uses a shadow copy, which is reloaded when enable goes from 0 to 1 and again on every match-clear. A new value therefore takes effect at the start of the next interval. While disabled, the counter rests at all ones. The first valid transition after enabling wraps it to zero, so the first interval is also D+1 transitions long.

Top module: `evc_event_counter`

## Requirements
- R1: After reset the count output is FFFFH and the interrupt output is 0.
- R2: While enable is 0 the count output is FFFFH, pin transitions are ignored and no interrupt is raised. Clearing enable during operation returns the count to FFFFH.
- R3: Edge select 01 makes only 0-to-1 transitions of the event pin valid.
- R4: Edge select 10 makes only 1-to-0 transitions of the event pin valid.
- R5: Edge select 11 makes every transition of the event pin valid.
- R6: Edge select 00 makes no transition valid, and the count holds.
- R7: With compare value D loaded at enable, the first interrupt comes on the (D+1)th valid transition, and the count then equals D.
- R8: A valid transition while the count equals the active compare value clears the count to 0000H. Any other valid transition increments the count. Interrupts therefore recur every D+1 valid transitions.
- R9: A compare write made while enabled does not change the current interval. It becomes active after the next match-clear.
- R10: With compare value 0000H every valid transition raises an interrupt, and the count stays 0000H.
- R11: The interrupt is high for exactly one clock per match. It is high in the clock in which the count first shows the compare value.
- R12: A pin change made between clock edges is reflected in the count output and the interrupt output after the third following rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| event_i | input | 1 | Asynchronous event pin |
| en_i | input | 1 | Counting enable |
| edge_sel_i | input | 2 | Valid transition: 00 none, 01 rising, 10 falling, 11 both |
| cmp_i | input | 16 | Compare value written by software |
| count_o | output | 16 | Current counter value |
| irq_o | output | 1 | One-clock interrupt pulse on match |

## Verification
A pin change takes two synchronizer clocks and one counter clock. The count and the interrupt therefore both appear after the third rising edge that follows the change. One directed test checks that they have not changed after the second edge and have changed after the third. All other stimulus holds each pin level for four clocks before the next change, so every transition is fully counted before outputs are sampled on a falling clock edge. The interrupt is a single-cycle pulse. It is counted by a monitor on every falling edge, and the checks compare these counts rather than trying to catch the pulse at a chosen instant.

// File: rtl/evc_pkg.sv
package evc_pkg;
   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;
endpackage

// File: rtl/evc_edge_det.sv
module evc_edge_det
   import evc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      pin_i,
   input  edge_sel_e sel_i,
   output logic      pulse_o
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("evc_edge_det: SYNC_STAGES must be at least 2");
   end

   logic [LAST:0] sync_q;
   logic          last_q;
   logic          rise, fall;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      sync_q[s] <= 1'b0;
         else if (s == 0)  sync_q[s] <= pin_i;
         else              sync_q[s] <= sync_q[(s == 0) ? 0 : s - 1];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) last_q <= 1'b0;
      else         last_q <= sync_q[LAST];
   end

   assign rise = sync_q[LAST] & ~last_q;
   assign fall = ~sync_q[LAST] & last_q;

   always_comb begin
      unique case (sel_i)
         EDGE_RISE: pulse_o = rise;
         EDGE_FALL: pulse_o = fall;
         EDGE_BOTH: pulse_o = rise | fall;
         default:   pulse_o = 1'b0;
      endcase
   end

   p_none_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == EDGE_NONE) |-> !pulse_o);
   p_rise_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == EDGE_RISE && pulse_o) |-> sync_q[LAST]);
   p_fall_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == EDGE_FALL && pulse_o) |-> !sync_q[LAST]);
endmodule

// File: rtl/evc_cmp_buf.sv
module evc_cmp_buf #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] d_i,
   output logic [CNT_W-1:0] q_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o <= '0;
      else if (load_i) q_o <= d_i;
   end

   p_buf_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(q_o));
endmodule

// File: rtl/evc_count_core.sv
module evc_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             pulse_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  logic [CNT_W-1:0] buf_i,
   output logic             buf_load_o,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o
);
   localparam logic [CNT_W-1:0] IDLE_VAL = '1;

   logic             en_q;
   logic             en_rise, step, hit;
   logic [CNT_W-1:0] cmp_act, cnt_nxt, buf_nxt;

   assign en_rise    = en_i & ~en_q;
   assign cmp_act    = en_rise ? cmp_i : buf_i;
   assign step       = en_i & pulse_i;
   assign hit        = (count_o == cmp_act);
   assign buf_load_o = en_rise | (step & hit);
   assign buf_nxt    = buf_load_o ? cmp_i : buf_i;

   always_comb begin
      if (!en_i)     cnt_nxt = IDLE_VAL;
      else if (step) cnt_nxt = hit ? '0 : count_o + CNT_W'(1);
      else           cnt_nxt = count_o;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q    <= 1'b0;
         count_o <= IDLE_VAL;
         irq_o   <= 1'b0;
      end else begin
         en_q    <= en_i;
         count_o <= cnt_nxt;
         irq_o   <= step & (cnt_nxt == buf_nxt);
      end
   end

   p_idle_value_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (count_o == IDLE_VAL && !irq_o));
   p_irq_needs_edge_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> $past(pulse_i && en_i));
   p_irq_at_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (count_o == buf_i));
   p_clear_on_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q && en_i && pulse_i && count_o == buf_i) |=> (count_o == '0));
   p_hold_no_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q && en_i && !pulse_i) |=> $stable(count_o));
endmodule

// File: rtl/evc_event_counter.sv
module evc_event_counter
   import evc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             event_i,
   input  logic             en_i,
   input  logic [1:0]       edge_sel_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("evc_event_counter: CNT_W must lie in 2..32");
   end

   logic             pulse;
   logic             buf_load;
   logic [CNT_W-1:0] buf_q;

   evc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_i   (event_i),
      .sel_i   (edge_sel_e'(edge_sel_i)),
      .pulse_o (pulse)
   );

   evc_cmp_buf #(.CNT_W(CNT_W)) u_buf (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (buf_load),
      .d_i    (cmp_i),
      .q_o    (buf_q)
   );

   evc_count_core #(.CNT_W(CNT_W)) u_core (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_i),
      .pulse_i    (pulse),
      .cmp_i      (cmp_i),
      .buf_i      (buf_q),
      .buf_load_o (buf_load),
      .count_o    (count_o),
      .irq_o      (irq_o)
   );
endmodule

// File: tb/evc_event_counter_tb.sv
module evc_event_counter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;

   typedef struct packed {
      logic [1:0]  sel;
      logic [15:0] cmp;
      logic [7:0]  toggles;
      logic [15:0] exp_cnt;
      logic [7:0]  exp_irq;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{2'b01, 16'd3, 8'd10, 16'd0,      8'd1},
      '{2'b10, 16'd3, 8'd10, 16'd0,      8'd1},
      '{2'b11, 16'd3, 8'd10, 16'd1,      8'd2},
      '{2'b00, 16'd3, 8'd10, 16'hFFFF,   8'd0},
      '{2'b11, 16'd0, 8'd7,  16'd0,      8'd7},
      '{2'b01, 16'd5, 8'd12, 16'd5,      8'd1},
      '{2'b11, 16'd1, 8'd9,  16'd0,      8'd4},
      '{2'b10, 16'd2, 8'd7,  16'd2,      8'd1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin = 1'b0;
   logic        en = 1'b0;
   logic [1:0]  sel = 2'b00;
   logic [15:0] cmp = 16'd0;
   logic [15:0] count;
   logic        irq;

   int checks = 0;
   int fails = 0;
   int irq_hi = 0;
   int irq_rise = 0;
   logic irq_prev = 1'b0;
   int base;

   always #(CLK_PERIOD/2) clk = ~clk;

   evc_event_counter dut_i (
      .clk_i(clk), .rst_ni(rst_n), .event_i(pin), .en_i(en),
      .edge_sel_i(sel), .cmp_i(cmp), .count_o(count), .irq_o(irq)
   );

   always @(negedge clk) begin
      if (irq) irq_hi++;
      if (irq && !irq_prev) irq_rise++;
      irq_prev <= irq;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic toggle();
      pin = ~pin;
      repeat (4) @(negedge clk);
   endtask

   function automatic string sel_tag(input logic [1:0] s);
      case (s)
         2'b01:   return "R3 R7 R8";
         2'b10:   return "R4 R7 R8";
         2'b11:   return "R5 R8 R10";
         default: return "R6";
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 count", int'(count), 16'hFFFF);
      check("R1 irq", int'(irq), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         en = 1'b0;
         @(negedge clk);
         if (pin) toggle();
         sel = VECS[i].sel;
         cmp = VECS[i].cmp;
         @(negedge clk);
         en = 1'b1;
         repeat (2) @(negedge clk);
         base = irq_rise;
         for (int t = 0; t < int'(VECS[i].toggles); t++) toggle();
         check({sel_tag(VECS[i].sel), " count"}, int'(count), int'(VECS[i].exp_cnt));
         check({sel_tag(VECS[i].sel), " irqs"}, irq_rise - base, int'(VECS[i].exp_irq));
      end

      // R12 latency and R11 pulse width, compare 0 (R10)
      en = 1'b0;
      @(negedge clk);
      if (pin) toggle();
      sel = 2'b11;
      cmp = 16'd0;
      @(negedge clk);
      en = 1'b1;
      repeat (3) @(negedge clk);
      pin = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R12 count after two edges", int'(count), 16'hFFFF);
      check("R12 irq after two edges", int'(irq), 0);
      @(negedge clk);
      check("R12 count after third edge", int'(count), 0);
      check("R11 irq high at match", int'(irq), 1);
      @(negedge clk);
      check("R11 irq one clock", int'(irq), 0);
      repeat (3) @(negedge clk);

      // R9 compare write mid-interval
      en = 1'b0;
      @(negedge clk);
      if (pin) toggle();
      cmp = 16'd3;
      @(negedge clk);
      en = 1'b1;
      repeat (2) @(negedge clk);
      base = irq_rise;
      toggle(); toggle();
      check("R9 count before write", int'(count), 1);
      cmp = 16'd1;
      toggle(); toggle();
      check("R9 old compare still active", int'(count), 3);
      check("R9 irq on old compare", irq_rise - base, 1);
      toggle(); toggle(); toggle();
      check("R9 new compare active", int'(count) + 16 * (irq_rise - base), 32'd32);

      // R2 disable mid-run
      en = 1'b0;
      repeat (2) @(negedge clk);
      base = irq_rise;
      toggle(); toggle(); toggle();
      check("R2 count held", int'(count), 16'hFFFF);
      check("R2 no irq", irq_rise - base, 0);

      check("R11 single-cycle pulses", irq_hi, irq_rise);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule